// File: doc/BRIEF.md
# TDM Output Frame Packer

This block assembles one serial output frame from the 24-bit samples of N converter channels (4 or 8) and shifts it out MSB first. Each channel comes with two status flags: a power flag from the power-down sequencer and a ready flag that goes high once a re-powered channel has valid data. A channel counts as eligible only while both flags are high.

A mode input picks one of two packings. In fixed packing every channel owns a slot in channel order, and an ineligible channel's slot is sent as zeros. In dynamic packing only eligible channels are sent, in channel order, with no gaps. A re-powered channel therefore joins the frame only once its data are ready.

A frame-start pulse latches the samples and the slot map. After that, each falling edge of the serial clock moves the output on by one bit. A one-cycle done pulse marks the end of the frame. The serial clock is sampled in the system clock domain. It must stay high for at least one system clock cycle and low for at least one.

Top module: `tdm_frame_packer`

## Requirements
- R1: During and right after reset, `sdout` is 0 and `frame_done` is 0.
- R2: With `pack_mode`=0 (fixed), a frame has N slots of 24 bits. Slot 0 carries channel 0, and the slots follow in channel order. Each sample goes out MSB first. `samples[i*24 +: 24]` is channel i.
- R3: In fixed mode, the slot of a channel whose `ch_power` or `ch_ready` bit is low is sent as 24 zero bits.
- R4: With `pack_mode`=1 (dynamic), only channels with both flags high are sent, in ascending channel order with no gaps. The frame is 24 times their count long.
- R5: In dynamic mode, a channel that is powered but not ready is left out. Once its ready bit rises, the next frame includes it at its channel-order position.
- R6: The first frame bit is on `sdout` in the cycle after the `frame_start` cycle. Each later bit appears in the cycle after a detected falling edge of `sclk`. Without a falling edge, `sdout` holds.
- R7: The falling edge that ends the last bit makes `frame_done` high for exactly one cycle. Outside a frame, `sdout` is 0.
- R8: If no channel is eligible when a frame starts, no bits are sent and `frame_done` stays low, in both modes.
- R9: The samples, flags and mode are captured on `frame_start`. Changes during a frame affect only later frames.
- R10: A `frame_start` pulse that arrives while a frame is being sent is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_start | input | 1 | Frame-sync / data-ready pulse, one cycle |
| sclk | input | 1 | Serial clock, sampled on clk |
| pack_mode | input | 1 | 0 fixed slots, 1 dynamic compaction |
| ch_power | input | N | Per-channel powered flag |
| ch_ready | input | N | Per-channel data-valid flag |
| samples | input | 24*N | Per-channel sample words, channel i at bits i*24+23..i*24 |
| sdout | output | 1 | Serial frame data, MSB first |
| frame_done | output | 1 | One-cycle pulse after the last bit |

## Verification
A wrong latched slot map shows as wrong bits on `sdout`. The error appears within 24 serial clocks of the slot involved, or as a done pulse that comes early or late. A wrong bit counter moves `frame_done` away from the edge that ends the last bit, which shows by the end of the frame. An edge detector that misses or doubles an edge misplaces every bit after that edge by one position, so the error shows at the next bit comparison.

// File: rtl/tdm_packer_pkg.sv
// Shared constants and types for the TDM frame packer.
package tdm_packer_pkg;
    localparam int SAMPLE_W = 24;

    typedef enum logic {
        PACK_FIXED   = 1'b0,
        PACK_DYNAMIC = 1'b1
    } pack_mode_e;
endpackage

// File: rtl/tdm_sclk_edge.sv
// Detects falling edges of the serial clock in the system clock domain.
// Assumes sclk is synchronous to clk and stays at each level for >= 1 clk.
module tdm_sclk_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk,
    output logic fall
);
    logic sclk_q;

    // Remember last sampled serial clock level.
    always_ff @(posedge clk) begin
        if (!rst_n) sclk_q <= 1'b0;
        else        sclk_q <= sclk;
    end

    assign fall = sclk_q & ~sclk;

    p_fall_after_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
        fall |=> !fall);
endmodule

// File: rtl/tdm_slot_mapper.sv
// Builds the left-aligned frame image and its bit length from the current
// channel status. Purely combinational; the shifter latches the result.
// Assumes samples are packed with channel i at [i*W +: W].
module tdm_slot_mapper
    import tdm_packer_pkg::*;
#(
    parameter int N_CH = 8,
    localparam int FRAME_W = N_CH * SAMPLE_W,
    localparam int LEN_W = $clog2(FRAME_W + 1),
    localparam int CNT_W = $clog2(N_CH + 1)
) (
    input  pack_mode_e           mode,
    input  logic [N_CH-1:0]      power,
    input  logic [N_CH-1:0]      ready,
    input  logic [FRAME_W-1:0]   samples,
    output logic [FRAME_W-1:0]   frame,
    output logic [LEN_W-1:0]     nbits
);
    logic [N_CH-1:0]  elig;
    logic [CNT_W-1:0] n_elig;

    assign elig = power & ready;

    // Place each channel into its slot and count eligible channels.
    always_comb begin
        logic [CNT_W-1:0] slot;
        frame  = '0;
        slot   = '0;
        n_elig = '0;
        for (int i = 0; i < N_CH; i++) begin
            if (mode == PACK_FIXED) begin
                if (elig[i])
                    frame[(N_CH-1-i)*SAMPLE_W +: SAMPLE_W] = samples[i*SAMPLE_W +: SAMPLE_W];
            end else if (elig[i]) begin
                frame[(N_CH-1-int'(slot))*SAMPLE_W +: SAMPLE_W] = samples[i*SAMPLE_W +: SAMPLE_W];
                slot = slot + 1'b1;
            end
            if (elig[i]) n_elig = n_elig + 1'b1;
        end
    end

    // Frame length: all slots in fixed mode, eligible slots in dynamic mode.
    always_comb begin
        if (n_elig == '0)
            nbits = '0;
        else if (mode == PACK_FIXED)
            nbits = LEN_W'(FRAME_W);
        else
            nbits = LEN_W'(int'(n_elig) * SAMPLE_W);
    end
endmodule

// File: rtl/tdm_frame_shifter.sv
// Holds the latched frame and shifts it out MSB first, one bit per serial
// falling edge. Assumes load is asserted only while not busy.
module tdm_frame_shifter
    import tdm_packer_pkg::*;
#(
    parameter int N_CH = 8,
    localparam int FRAME_W = N_CH * SAMPLE_W,
    localparam int LEN_W = $clog2(FRAME_W + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [FRAME_W-1:0] frame,
    input  logic [LEN_W-1:0]   nbits,
    input  logic               fall,
    output logic               sdout,
    output logic               done,
    output logic               busy
);
    logic [FRAME_W-1:0] shreg;
    logic [LEN_W-1:0]   left;

    // Load a new frame or advance by one bit on each serial falling edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg <= '0;
            left  <= '0;
            busy  <= 1'b0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            if (load) begin
                shreg <= frame;
                left  <= nbits;
                busy  <= (nbits != '0);
            end else if (busy && fall) begin
                shreg <= shreg << 1;
                left  <= left - 1'b1;
                if (left == LEN_W'(1)) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end
            end
        end
    end

    assign sdout = busy & shreg[FRAME_W-1];

    p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    p_done_ends_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
    p_idle_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !sdout);
    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !fall && !load) |=> ($stable(shreg) && $stable(left)));
    p_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (load && nbits == '0) |=> (!busy && !done));
endmodule

// File: rtl/tdm_frame_packer.sv
// Top of the TDM output frame packer: maps channels to slots, latches the
// frame on frame_start while idle, and shifts it out on serial falling edges.
// Assumes frame_start is a one-cycle pulse synchronous to clk.
module tdm_frame_packer
    import tdm_packer_pkg::*;
#(
    parameter int N_CH = 8,
    localparam int FRAME_W = N_CH * SAMPLE_W,
    localparam int LEN_W = $clog2(FRAME_W + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               frame_start,
    input  logic               sclk,
    input  logic               pack_mode,
    input  logic [N_CH-1:0]    ch_power,
    input  logic [N_CH-1:0]    ch_ready,
    input  logic [FRAME_W-1:0] samples,
    output logic               sdout,
    output logic               frame_done
);
    logic [FRAME_W-1:0] map_frame;
    logic [LEN_W-1:0]   map_nbits;
    logic               fall;
    logic               busy;
    logic               load;
    pack_mode_e         mode;

    assign mode = pack_mode_e'(pack_mode);
    assign load = frame_start & ~busy;

    tdm_sclk_edge u_edge (
        .clk  (clk),
        .rst_n(rst_n),
        .sclk (sclk),
        .fall (fall)
    );

    tdm_slot_mapper #(.N_CH(N_CH)) u_map (
        .mode   (mode),
        .power  (ch_power),
        .ready  (ch_ready),
        .samples(samples),
        .frame  (map_frame),
        .nbits  (map_nbits)
    );

    tdm_frame_shifter #(.N_CH(N_CH)) u_shift (
        .clk  (clk),
        .rst_n(rst_n),
        .load (load),
        .frame(map_frame),
        .nbits(map_nbits),
        .fall (fall),
        .sdout(sdout),
        .done (frame_done),
        .busy (busy)
    );

    p_dyn_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (load && mode == PACK_DYNAMIC) |->
            int'(map_nbits) == SAMPLE_W * $countones(ch_power & ch_ready));
    p_busy_ignore_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && frame_start && !fall) |=> $stable(sdout));
    p_start_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (load && (ch_power & ch_ready) != '0) |=> busy);
endmodule

// File: tb/tdm_frame_packer_tb.sv
module tdm_frame_packer_tb_top;
    localparam int NCH = 8;
    localparam int SW  = 24;
    localparam int FW  = NCH * SW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          frame_start = 1'b0;
    logic          sclk = 1'b0;
    logic          pack_mode = 1'b0;
    logic [NCH-1:0] ch_power = '0;
    logic [NCH-1:0] ch_ready = '0;
    logic [FW-1:0] samples = '0;
    logic          sdout;
    logic          frame_done;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    tdm_frame_packer #(.N_CH(NCH)) dut_i (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .sclk(sclk),
        .pack_mode(pack_mode), .ch_power(ch_power), .ch_ready(ch_ready),
        .samples(samples), .sdout(sdout), .frame_done(frame_done)
    );

    always #5 clk = ~clk;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Expected frame: accumulate slots in order, then left-align.
    function automatic void build_exp(output logic [FW-1:0] img, output int len);
        logic [FW-1:0] acc = '0;
        int n = 0;
        for (int c = 0; c < NCH; c++) begin
            logic ok = ch_power[c] && ch_ready[c];
            logic [SW-1:0] w = samples[c*SW +: SW];
            if (pack_mode == 1'b0) begin
                acc = (acc << SW) | FW'(ok ? w : '0);
                n++;
            end else if (ok) begin
                acc = (acc << SW) | FW'(w);
                n++;
            end
        end
        if ((ch_power & ch_ready) == '0) n = 0;
        len = n * SW;
        img = (n == 0) ? '0 : acc << (FW - len);
    endfunction

    task automatic randomize_inputs();
        for (int c = 0; c < NCH; c++) samples[c*SW +: SW] = SW'($urandom);
        ch_power = NCH'($urandom);
        ch_ready = NCH'($urandom) | NCH'($urandom);
    endtask

    // Run one frame; at bit index mid (if >= 0) disturb inputs, pulse
    // frame_start and hold sclk still for a few cycles.
    task automatic run_frame(input string req, input int mid);
        logic [FW-1:0] img;
        int len;
        int bad = -1;
        logic got = 1'b0;
        logic want = 1'b0;
        build_exp(img, len);
        @(negedge clk); frame_start = 1'b1;
        @(negedge clk); frame_start = 1'b0;
        if (len == 0) begin
            logic seen = 1'b0;
            logic any = 1'b0;
            for (int k = 0; k < 10; k++) begin
                sclk = 1'b1; @(negedge clk); seen |= frame_done; any |= sdout;
                sclk = 1'b0; @(negedge clk); seen |= frame_done; any |= sdout;
            end
            check(!seen && !any, "R8", "empty frame done/sdout", {seen, any}, 0);
            return;
        end
        for (int b = 0; b < len; b++) begin
            if (b == mid) begin
                logic held = sdout;
                logic stable = 1'b1;
                randomize_inputs();
                pack_mode = ~pack_mode;
                frame_start = 1'b1;
                @(negedge clk); frame_start = 1'b0; stable &= (sdout == held);
                for (int k = 0; k < 4; k++) begin
                    @(negedge clk); stable &= (sdout == held);
                end
                check(stable, "R6", "sdout held without sclk edge", sdout, held);
            end
            if (bad < 0 && sdout !== img[FW-1-b]) begin
                bad = b; got = sdout; want = img[FW-1-b];
            end
            if (b != len - 1 && frame_done) begin
                check(1'b0, "R7", "early frame_done", b, len);
            end
            sclk = 1'b1; @(negedge clk);
            sclk = 1'b0; @(negedge clk);
        end
        if (bad >= 0)
            $display("  mismatch at bit %0d of %0d", bad, len);
        check(bad < 0, req, "frame bit", got, want);
        check(frame_done === 1'b1, "R7", "frame_done after last bit", frame_done, 1);
        @(negedge clk);
        check(frame_done === 1'b0 && sdout === 1'b0, "R7", "done single cycle, idle low",
              {frame_done, sdout}, 0);
    endtask

    initial begin
        void'($urandom(32'h1234_5678));
        repeat (3) @(negedge clk);
        check(sdout === 1'b0 && frame_done === 1'b0, "R1", "reset outputs", {sdout, frame_done}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(sdout === 1'b0 && frame_done === 1'b0, "R1", "after reset", {sdout, frame_done}, 0);

        // R2: fixed mode, all channels on.
        for (int c = 0; c < NCH; c++) samples[c*SW +: SW] = SW'($urandom);
        pack_mode = 1'b0; ch_power = '1; ch_ready = '1;
        run_frame("R2", -1);

        // R3: fixed mode with channels 2 and 5 off.
        ch_power = 8'b1101_1011;
        run_frame("R3", -1);

        // R4: dynamic compaction of the same status.
        pack_mode = 1'b1;
        run_frame("R4", -1);

        // R5: channel 3 powered but not ready, then ready.
        ch_power = '1; ch_ready = 8'b1111_0111;
        run_frame("R5", -1);
        ch_ready = '1;
        run_frame("R5", -1);

        // R8: nothing eligible in both modes.
        ch_power = '0;
        run_frame("R8", -1);
        pack_mode = 1'b0;
        ch_power = '1; ch_ready = '0;
        run_frame("R8", -1);

        // R9/R10: disturb inputs and pulse frame_start mid-frame.
        ch_ready = '1; ch_power = 8'b0110_1001; pack_mode = 1'b1;
        run_frame("R9", 30);
        run_frame("R10", 5);
        ch_power = 8'b1000_0001; pack_mode = 1'b0;
        run_frame("R9", 100);

        // Random frames in both modes.
        for (int t = 0; t < 30; t++) begin
            randomize_inputs();
            pack_mode = 1'($urandom);
            run_frame(pack_mode ? "R4" : "R2", (t % 5 == 0) ? int'($urandom_range(0, 20)) : -1);
        end

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog run did not complete actual=0 expected=1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule